// File: doc/BRIEF.md
# Smart-Card Receive Parity Checker and NACK Requester

This block sits on the receive path of a character-mode (T=0) smart-card interface. It checks the even parity of every received character. When the parity is wrong, it decides whether the character should be refused by pulling the shared I/O line low for one bit time. The decision depends on two settings. An inhibit setting suppresses every refusal. A successive-limit setting lets only the first few consecutive bad characters be refused; a 3-bit iteration limit sets how many. After that, errors are only flagged.

A bit-sampling front end outside this block feeds it. That front end gives one strobe for each sampled bit, the sampled value, and a character-done mark on the parity bit's strobe. The block keeps a saturating count of consecutive parity failures. It produces a one-cycle error flag and a drive request. An external open-drain pad turns the drive request into a low level on the line. Bit timing is a parameter given in clock cycles.

Top module: `sc_nack_rx`

## Requirements
- R1: While `t0_mode` is 0 the block never raises `nack_drv`, and `err_cnt` is forced to 0 in the cycle after any cycle spent in that state. Parity errors are still flagged on `par_err`.
- R2: With `nack_inhibit` = 1, a parity error never raises `nack_drv`, whatever the values of `succ_limit_en` and `max_iter`.
- R3: With `nack_inhibit` = 0 and `succ_limit_en` = 0 in mode, every character with a parity error produces exactly one NACK pulse.
- R4: In mode, each character with a parity error raises `err_cnt` by one in the cycle after its character-done strobe. The count saturates at 7.
- R5: With `succ_limit_en` = 1 and `nack_inhibit` = 0, a bad character is refused only if `err_cnt` is below `max_iter` before that character. Once `err_cnt` reaches `max_iter`, further errors give no NACK.
- R6: `max_iter` = 0 with `succ_limit_en` = 1 gives no NACK at all.
- R7: A character with correct parity clears `err_cnt` to 0 in the cycle after its character-done strobe.
- R8: Parity is even over the 8 data bits and the parity bit. Only cycles with `bit_stb` = 1 contribute a bit, and the strobe with `char_done` = 1 carries the parity bit. A mismatch raises `par_err` for exactly the one cycle after that strobe. At all other times `par_err` is 0.
- R9: A NACK pulse is high from HALF+1 cycles after the parity strobe cycle to HALF+BIT_CYC cycles after it, inclusive, where HALF = BIT_CYC/2. That is exactly BIT_CYC cycles.
- R10: After reset, `nack_drv`, `par_err` and `err_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled line value, valid with `bit_stb` |
| char_done | input | 1 | Marks the strobe that carries the parity bit |
| t0_mode | input | 1 | Character-mode smart-card operation enabled |
| nack_inhibit | input | 1 | Suppress all NACKs |
| succ_limit_en | input | 1 | Cap NACKs after `max_iter` consecutive errors |
| max_iter | input | ITER_W | Maximum number of refused consecutive errors |
| nack_drv | output | 1 | Request to pull the I/O line low |
| par_err | output | 1 | One-cycle parity error pulse |
| err_cnt | output | ITER_W | Consecutive parity error count |

## Verification
Call the cycle of the strobe that has `char_done` set cycle T. `par_err` and `err_cnt` are due in cycle T+1. The NACK window runs from T+HALF+1 to T+HALF+BIT_CYC. The bench drives inputs on falling edges and samples each result on the falling edge inside the cycle it is due. For the NACK it checks four points: the last quiet cycle before the window, the first and last cycles of the window, and the first cycle after it. It spaces characters far enough apart that one NACK window ends before the next character starts. A bench model computes the expected flag, count and refusal before each character is sent.

// File: rtl/sc_nack_pkg.sv
package sc_nack_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_WAIT  = 2'd1,
        TMR_DRIVE = 2'd2
    } tmr_state_e;

    // Saturating increment for the error count
    function automatic logic [7:0] sat_inc8(input logic [7:0] v, input logic [7:0] vmax);
        return (v >= vmax) ? vmax : v + 8'd1;
    endfunction

endpackage

// File: rtl/sc_par_acc.sv
// Running parity over strobed bits; reports at the parity-bit strobe.
module sc_par_acc (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic char_done,
    output logic chk_vld,
    output logic chk_bad
);
    typedef struct packed {
        logic acc;
    } acc_regs_t;

    acc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        chk_vld = bit_stb && char_done;
        // Even parity: XOR of all nine bits must be zero
        chk_bad = r_q.acc ^ rx_bit;
        if (bit_stb) begin
            if (char_done) begin
                r_d.acc = 1'b0;
            end else begin
                r_d.acc = r_q.acc ^ rx_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/sc_err_policy.sv
// Consecutive error counting and the refuse/accept decision.
module sc_err_policy #(
    parameter int ITER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_vld,
    input  logic              chk_bad,
    input  logic              t0_mode,
    input  logic              nack_inhibit,
    input  logic              succ_limit_en,
    input  logic [ITER_W-1:0] max_iter,
    output logic              par_err,
    output logic [ITER_W-1:0] err_cnt,
    output logic              nack_start
);
    localparam logic [ITER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              perr;
        logic [ITER_W-1:0] cnt;
        logic              start;
    } pol_regs_t;

    pol_regs_t r_d, r_q;
    logic      under_cap;
    logic      refuse;

    always_comb begin
        r_d       = r_q;
        under_cap = (r_q.cnt < max_iter);
        refuse    = t0_mode && chk_bad && !nack_inhibit &&
                    (!succ_limit_en || under_cap);
        r_d.perr  = 1'b0;
        r_d.start = 1'b0;
        if (!t0_mode) begin
            r_d.cnt = '0;
        end
        if (chk_vld) begin
            r_d.perr  = chk_bad;
            r_d.start = refuse;
            if (!t0_mode || !chk_bad) begin
                r_d.cnt = '0;
            end else if (r_q.cnt != CNT_MAX) begin
                r_d.cnt = r_q.cnt + ITER_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign par_err    = r_q.perr;
    assign err_cnt    = r_q.cnt;
    assign nack_start = r_q.start;
endmodule

// File: rtl/sc_nack_timer.sv
// Delays the NACK by half a bit and holds it for one bit time.
module sc_nack_timer
    import sc_nack_pkg::*;
#(
    parameter int BIT_CYC  = 16,
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic drive
);
    localparam int TW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam logic [TW-1:0] WAIT_LD  = TW'(HALF_CYC - 2);
    localparam logic [TW-1:0] DRIVE_LD = TW'(BIT_CYC - 1);

    typedef struct packed {
        tmr_state_e    st;
        logic [TW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TMR_WAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = TMR_DRIVE;
                    r_d.cnt = DRIVE_LD;
                end else begin
                    r_d.cnt = r_q.cnt - TW'(1);
                end
            end
            TMR_DRIVE: begin
                if (r_q.cnt == '0) begin
                    r_d.st = TMR_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - TW'(1);
                end
            end
            default: begin
                r_d.st  = TMR_IDLE;
                r_d.cnt = '0;
            end
        endcase
        // A new request restarts the delay
        if (start) begin
            r_d.st  = TMR_WAIT;
            r_d.cnt = WAIT_LD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: TMR_IDLE, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign drive = (r_q.st == TMR_DRIVE);
endmodule

// File: rtl/sc_nack_rx.sv
module sc_nack_rx #(
    parameter int BIT_CYC = 16,
    parameter int ITER_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rx_bit,
    input  logic              char_done,
    input  logic              t0_mode,
    input  logic              nack_inhibit,
    input  logic              succ_limit_en,
    input  logic [ITER_W-1:0] max_iter,
    output logic              nack_drv,
    output logic              par_err,
    output logic [ITER_W-1:0] err_cnt
);
    localparam int HALF_CYC = BIT_CYC / 2;

    logic chk_vld;
    logic chk_bad;
    logic nack_start;

    sc_par_acc u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .rx_bit    (rx_bit),
        .char_done (char_done),
        .chk_vld   (chk_vld),
        .chk_bad   (chk_bad)
    );

    sc_err_policy #(.ITER_W(ITER_W)) u_pol (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk_vld       (chk_vld),
        .chk_bad       (chk_bad),
        .t0_mode       (t0_mode),
        .nack_inhibit  (nack_inhibit),
        .succ_limit_en (succ_limit_en),
        .max_iter      (max_iter),
        .par_err       (par_err),
        .err_cnt       (err_cnt),
        .nack_start    (nack_start)
    );

    sc_nack_timer #(.BIT_CYC(BIT_CYC), .HALF_CYC(HALF_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nack_start),
        .drive (nack_drv)
    );
endmodule

// File: rtl/sc_nack_rx_chk.sv
module sc_nack_rx_chk #(
    parameter int ITER_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              t0_mode,
    input logic              nack_inhibit,
    input logic              succ_limit_en,
    input logic [ITER_W-1:0] max_iter,
    input logic              chk_vld,
    input logic              chk_bad,
    input logic              nack_start,
    input logic              par_err,
    input logic [ITER_W-1:0] err_cnt
);
    localparam logic [ITER_W-1:0] CMAX = '1;

    p_mode_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !t0_mode |=> (err_cnt == '0));

    p_no_start_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && !t0_mode) |=> !nack_start);

    p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && nack_inhibit) |=> !nack_start);

    p_every_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && chk_bad && t0_mode && !nack_inhibit && !succ_limit_en) |=> nack_start);

    p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && chk_bad && t0_mode) |=>
        (($past(err_cnt) == CMAX) ? (err_cnt == CMAX)
                                  : (err_cnt == $past(err_cnt) + ITER_W'(1))));

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && succ_limit_en && (err_cnt >= max_iter)) |=> !nack_start);

    p_good_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && !chk_bad) |=> (err_cnt == '0));

    p_perr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |=> !par_err);
endmodule

bind sc_nack_rx sc_nack_rx_chk #(.ITER_W(ITER_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .t0_mode       (t0_mode),
    .nack_inhibit  (nack_inhibit),
    .succ_limit_en (succ_limit_en),
    .max_iter      (max_iter),
    .chk_vld       (chk_vld),
    .chk_bad       (chk_bad),
    .nack_start    (nack_start),
    .par_err       (par_err),
    .err_cnt       (err_cnt)
);

// File: tb/sc_nack_rx_bench.sv
`timescale 1ns/1ps
module sc_nack_rx_bench;
    localparam int BIT_CYC = 16;
    localparam int HALF    = BIT_CYC / 2;
    localparam int ITER_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, rx_bit = 1'b0, char_done = 1'b0;
    logic t0_mode = 1'b1, nack_inhibit = 1'b0, succ_limit_en = 1'b0;
    logic [ITER_W-1:0] max_iter = '0;
    logic nack_drv, par_err;
    logic [ITER_W-1:0] err_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sc_nack_rx #(.BIT_CYC(BIT_CYC), .ITER_W(ITER_W)) u_sc_nack_rx (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
        .char_done(char_done), .t0_mode(t0_mode), .nack_inhibit(nack_inhibit),
        .succ_limit_en(succ_limit_en), .max_iter(max_iter),
        .nack_drv(nack_drv), .par_err(par_err), .err_cnt(err_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit model_refuse(input bit bad);
        return t0_mode && bad && !nack_inhibit &&
               (!succ_limit_en || (m_cnt < int'(max_iter)));
    endfunction

    function automatic int model_next_cnt(input bit bad);
        if (!t0_mode || !bad) return 0;
        return (m_cnt >= 7) ? 7 : m_cnt + 1;
    endfunction

    // Send one character; bad=1 corrupts the parity bit
    task automatic send_char(input logic [7:0] data, input bit bad, input int gap);
        bit exp_nack;
        logic pbit;
        exp_nack = model_refuse(bad);
        pbit = (^data) ^ bad;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            bit_stb = 1'b1;
            rx_bit = (i < 8) ? data[i] : pbit;
            char_done = (i == 8);
            if (i < 8) begin
                @(negedge clk);
                bit_stb = 1'b0;
                rx_bit = ~rx_bit; // noise between strobes must be ignored
                repeat (gap) @(negedge clk);
            end
        end
        // now in cycle T+1
        @(negedge clk);
        bit_stb = 1'b0;
        char_done = 1'b0;
        m_cnt = model_next_cnt(bad);
        chk("R8 par_err", par_err, bad);
        chk("R4/R7 err_cnt", err_cnt, m_cnt);
        @(negedge clk);
        chk("R8 par_err one cycle", par_err, 0);
        repeat (HALF - 2) @(negedge clk);           // cycle T+HALF
        chk("R9 nack before window", nack_drv, 0);
        @(negedge clk);                              // T+HALF+1
        chk("R3/R5 nack window start", nack_drv, exp_nack);
        repeat (BIT_CYC - 1) @(negedge clk);         // T+HALF+BIT_CYC
        chk("R9 nack window end", nack_drv, exp_nack);
        @(negedge clk);
        chk("R9 nack after window", nack_drv, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5C0DE));
        repeat (3) @(negedge clk);
        chk("R10 nack_drv reset", nack_drv, 0);
        chk("R10 par_err reset", par_err, 0);
        chk("R10 err_cnt reset", err_cnt, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every error refused
        send_char(8'hA5, 1, 0);
        send_char(8'h3C, 1, 1);
        send_char(8'h00, 0, 2);   // R7 clears
        // R5: limit 2
        succ_limit_en = 1'b1; max_iter = 3'd2;
        for (int k = 0; k < 4; k++) send_char(8'h5A + 8'(k), 1, 1);
        send_char(8'hFF, 0, 0);
        // R6: limit 0
        max_iter = 3'd0;
        send_char(8'h81, 1, 0);
        // R4 saturation with R2 inhibit
        nack_inhibit = 1'b1; succ_limit_en = 1'b0;
        for (int k = 0; k < 9; k++) send_char(8'(k * 17), 1, 0);
        succ_limit_en = 1'b1; max_iter = 3'd7;
        send_char(8'h11, 1, 0);   // R2 with limit set
        // R1: mode off
        nack_inhibit = 1'b0; succ_limit_en = 1'b0; t0_mode = 1'b0;
        send_char(8'h77, 1, 0);
        send_char(8'h76, 1, 1);
        t0_mode = 1'b1;
        @(negedge clk);
        chk("R1 count cleared after mode off", err_cnt, 0);

        // Constrained random
        for (int n = 0; n < 60; n++) begin
            t0_mode       = ($urandom % 10) != 0;
            nack_inhibit  = ($urandom % 5) == 0;
            succ_limit_en = $urandom % 2;
            max_iter      = 3'($urandom % 8);
            @(negedge clk);
            if (!t0_mode) m_cnt = 0;
            send_char(8'($urandom), ($urandom % 3) != 0, $urandom % 3);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule